// File: doc/BRIEF.md
# Four-Channel Two-Wire Mux Connection Controller

This block decides which of four downstream two-wire channels a multiplexer connects to its upstream bus. A decoded register interface hands it a connection command as a four-bit request mask. Each request can be written with one strobe. For each channel the block samples the idle logic level through a synchronizer. By default it closes only the switches of requested channels that read high at the moment the command is taken. A configuration bit can turn this check off so that the request is applied exactly as written.

The block enables the upstream-downstream buffer and raises READY only when at least one channel is connected and the upstream bus is not stuck low. A stuck-low fault that arrives while the bus is linked opens every switch and drops READY. The four active-low alert lines are merged into one alert output, and this merge keeps working while the enable input is low. When the enable input is low or the supply is in lockout, the block holds every switch open, clears its configuration and ignores commands. During lockout the alert output is also released high.

The controller is a three-state machine:
- `ST_OFF`: disabled or in lockout.
- `ST_IDLE`: enabled, with no channel connected.
- `ST_LINKED`: buffers active.

Its transitions are named as follows:
- `power_up`: OFF to IDLE, taken one cycle after enable and supply are both good.
- `link`: IDLE or LINKED to LINKED, on a command whose effective mask is non-zero and no stuck-low is present.
- `refuse`: IDLE or LINKED to IDLE, on a command whose effective mask is zero or that arrives with stuck-low present.
- `fault_drop`: LINKED to IDLE, on stuck-low.
- `shut_down`: any state to OFF.

The `ch_en_o` output doubles as the status of the effective connected mask, so a master can see which requested channels were refused.

Top module: `chanmux_conn_ctrl`

## Requirements
- R1: After reset, `ch_en_o` is 0000, and `buf_en_o` and `ready_o` are low.
- R2: When the override bit is clear, a command connects exactly those requested channels (bit i of `cmd_mask_i` = channel i) whose synchronized level is high. The result appears on `ch_en_o` after the clock edge that samples `cmd_valid_i`.
- R3: When the override bit is set (written through `cfg_we_i`/`cfg_force_i`), a command connects exactly the requested channels, whatever their levels.
- R4: `buf_en_o` and `ready_o` are high exactly when at least one channel is connected.
- R5: A command taken while `stuck_low_i` is high connects no channel, and buffers and READY stay low.
- R6: If `stuck_low_i` is high while linked, all channels open and `buf_en_o`/`ready_o` fall at the next clock edge, even if a command arrives in the same cycle.
- R7: While `en_i` is low, all channels open, the override bit clears, and commands and configuration writes are ignored. Commands are accepted from the second cycle after `en_i` rises.
- R8: While the supply is good, `alert_n_o` is low whenever any bit of `alert_n_i` is low, including while `en_i` is low.
- R9: While `uvlo_i` is high, `alert_n_o` is released high, all channels are open, and commands are ignored.
- R10: A downstream level passes through two synchronizer flops. A level that rises one cycle before the command edge is still seen as low.
- R11: A new command while linked replaces the connected mask. A command whose effective mask is zero disconnects everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable; low resets control state |
| uvlo_i | input | 1 | Supply lockout active |
| cfg_we_i | input | 1 | Write strobe for the override bit |
| cfg_force_i | input | 1 | Override value: 1 connects without level check |
| cmd_valid_i | input | 1 | Connection command strobe |
| cmd_mask_i | input | 4 | Requested channel mask |
| stuck_low_i | input | 1 | Upstream stuck-low fault flag |
| ch_level_i | input | 4 | Asynchronous downstream idle levels |
| alert_n_i | input | 4 | Active-low alert inputs |
| ch_en_o | output | 4 | Channel switch enables / connected status |
| buf_en_o | output | 1 | Upstream-downstream buffer enable |
| ready_o | output | 1 | High when linked |
| alert_n_o | output | 1 | Merged active-low alert |

## Verification
The hardest situation to reach is a command that lands exactly as a downstream level changes. Here the decision must use the synchronized value, not the live pin. The stimulus raises a level one cycle before the command strobe and expects the refusal. It then repeats the command after the level has settled and expects the connection. A second delicate case is a stuck-low fault that coincides with a command while linked. The bench drives both in the same cycle and expects the disconnect to win.

// File: rtl/chanmux_conn_pkg.sv
package chanmux_conn_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_LINKED = 2'd2
    } conn_state_e;
endpackage

// File: rtl/chanmux_lvl_sync.sv
module chanmux_lvl_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0] chain_q [WIDTH];

    for (genvar c = 0; c < WIDTH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[c] <= '0;
            else        chain_q[c] <= {chain_q[c][STAGES-2:0], d_i[c]};
        end
        assign q_o[c] = chain_q[c][STAGES-1];
    end
endmodule

// File: rtl/chanmux_alert_merge.sv
module chanmux_alert_merge #(
    parameter int WIDTH = 4
) (
    input  logic             lockout_i,
    input  logic [WIDTH-1:0] alert_n_i,
    output logic             alert_n_o
);
    // released (high) during lockout, otherwise wired-AND of the inputs
    assign alert_n_o = lockout_i | (&alert_n_i);
endmodule

// File: rtl/chanmux_conn_ctrl.sv
module chanmux_conn_ctrl
    import chanmux_conn_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              uvlo_i,
    input  logic              cfg_we_i,
    input  logic              cfg_force_i,
    input  logic              cmd_valid_i,
    input  logic [NUM_CH-1:0] cmd_mask_i,
    input  logic              stuck_low_i,
    input  logic [NUM_CH-1:0] ch_level_i,
    input  logic [NUM_CH-1:0] alert_n_i,
    output logic [NUM_CH-1:0] ch_en_o,
    output logic              buf_en_o,
    output logic              ready_o,
    output logic              alert_n_o
);
    localparam logic [NUM_CH-1:0] NONE = '0;

    conn_state_e       state_q, state_d;
    logic [NUM_CH-1:0] mask_q, mask_d;
    logic              force_q, force_d;
    logic [NUM_CH-1:0] lvl_sync;
    logic [NUM_CH-1:0] eff_mask;
    logic              active;

    chanmux_lvl_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ch_level_i),
        .q_o   (lvl_sync)
    );

    chanmux_alert_merge #(.WIDTH(NUM_CH)) alert_i (
        .lockout_i (uvlo_i),
        .alert_n_i (alert_n_i),
        .alert_n_o (alert_n_o)
    );

    assign active   = en_i & ~uvlo_i;
    assign eff_mask = force_q ? cmd_mask_i : (cmd_mask_i & lvl_sync);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            mask_q  <= NONE;
            force_q <= 1'b0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
            force_q <= force_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        mask_d  = mask_q;
        force_d = force_q;
        if (!active) begin
            state_d = ST_OFF;          // shut_down
            mask_d  = NONE;
            force_d = 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_IDLE;  // power_up
                end
                ST_IDLE, ST_LINKED: begin
                    if (cfg_we_i) force_d = cfg_force_i;
                    if (state_q == ST_LINKED && stuck_low_i) begin
                        state_d = ST_IDLE;  // fault_drop
                        mask_d  = NONE;
                    end else if (cmd_valid_i) begin
                        if (stuck_low_i || eff_mask == NONE) begin
                            state_d = ST_IDLE;  // refuse
                            mask_d  = NONE;
                        end else begin
                            state_d = ST_LINKED;  // link
                            mask_d  = eff_mask;
                        end
                    end
                end
                default: begin
                    state_d = ST_OFF;
                    mask_d  = NONE;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        ch_en_o  = mask_q;
        buf_en_o = (state_q == ST_LINKED);
        ready_o  = (state_q == ST_LINKED);
    end
endmodule

// File: rtl/chanmux_conn_ctrl_chk.sv
module chanmux_conn_ctrl_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              uvlo_i,
    input logic              cmd_valid_i,
    input logic [NUM_CH-1:0] cmd_mask_i,
    input logic              stuck_low_i,
    input logic [NUM_CH-1:0] alert_n_i,
    input logic [NUM_CH-1:0] ch_en_o,
    input logic              buf_en_o,
    input logic              ready_o,
    input logic              alert_n_o
);
    assert_new_bits_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ch_en_o & ~$past(ch_en_o) & ~$past(cmd_mask_i)) == '0));

    assert_new_bits_need_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid_i |=> ((ch_en_o & ~$past(ch_en_o)) == '0));

    assert_ready_has_channel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (ch_en_o != '0));

    assert_no_link_on_stuck_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && stuck_low_i && !buf_en_o) |=> !buf_en_o);

    assert_fault_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en_o && stuck_low_i) |=> (!buf_en_o && ch_en_o == '0));

    assert_disable_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (ch_en_o == '0 && !ready_o));

    assert_alert_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!uvlo_i && alert_n_i != '1) |-> !alert_n_o);

    assert_lockout_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_i |-> alert_n_o);
endmodule

bind chanmux_conn_ctrl chanmux_conn_ctrl_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .uvlo_i      (uvlo_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_mask_i  (cmd_mask_i),
    .stuck_low_i (stuck_low_i),
    .alert_n_i   (alert_n_i),
    .ch_en_o     (ch_en_o),
    .buf_en_o    (buf_en_o),
    .ready_o     (ready_o),
    .alert_n_o   (alert_n_o)
);

// File: tb/chanmux_conn_ctrl_tb.sv
module chanmux_conn_ctrl_tb_top;
    localparam int CLK_P = 10;
    localparam int NV    = 8;
    // {force, level[3:0], stuck, mask[3:0], expected[3:0]}
    localparam logic [13:0] VEC [NV] = '{
        {1'b0, 4'b1111, 1'b0, 4'b0101, 4'b0101},
        {1'b0, 4'b0011, 1'b0, 4'b1111, 4'b0011},
        {1'b0, 4'b0000, 1'b0, 4'b1010, 4'b0000},
        {1'b1, 4'b0000, 1'b0, 4'b1010, 4'b1010},
        {1'b1, 4'b1111, 1'b1, 4'b1111, 4'b0000},
        {1'b0, 4'b1100, 1'b0, 4'b0110, 4'b0100},
        {1'b1, 4'b0001, 1'b0, 4'b1000, 4'b1000},
        {1'b0, 4'b1111, 1'b1, 4'b0001, 4'b0000}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b1, uvlo_i = 1'b0, cfg_we_i = 1'b0, cfg_force_i = 1'b0;
    logic       cmd_valid_i = 1'b0, stuck_low_i = 1'b0;
    logic [3:0] cmd_mask_i = '0, ch_level_i = '0, alert_n_i = 4'hF;
    logic [3:0] ch_en_o;
    logic       buf_en_o, ready_o, alert_n_o;
    int         checks = 0, errors = 0;

    always #(CLK_P/2) clk = ~clk;

    chanmux_conn_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .uvlo_i(uvlo_i),
        .cfg_we_i(cfg_we_i), .cfg_force_i(cfg_force_i),
        .cmd_valid_i(cmd_valid_i), .cmd_mask_i(cmd_mask_i),
        .stuck_low_i(stuck_low_i), .ch_level_i(ch_level_i),
        .alert_n_i(alert_n_i), .ch_en_o(ch_en_o), .buf_en_o(buf_en_o),
        .ready_o(ready_o), .alert_n_o(alert_n_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_force(input logic f);
        @(negedge clk); cfg_we_i = 1'b1; cfg_force_i = f;
        @(negedge clk); cfg_we_i = 1'b0;
    endtask

    task automatic command(input logic [3:0] m);
        @(negedge clk); cmd_valid_i = 1'b1; cmd_mask_i = m;
        @(negedge clk); cmd_valid_i = 1'b0;
    endtask

    task automatic check_link(input string req, input logic [3:0] exp);
        chk(req, {4'h0, ch_en_o}, {4'h0, exp});
        chk(req, {6'h0, buf_en_o, ready_o}, {6'h0, {2{exp != 4'h0}}});
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(2);
        check_link("R1 reset", 4'h0);
        rst_n = 1'b1;
        idle(3);
        check_link("R1 after reset", 4'h0);

        // vector table: R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            set_force(VEC[v][13]);
            ch_level_i  = VEC[v][12:9];
            stuck_low_i = VEC[v][8];
            idle(3);
            command(VEC[v][7:4]);
            check_link($sformatf("R2 R3 R4 R5 vector %0d", v), VEC[v][3:0]);
            stuck_low_i = 1'b0;
        end

        // R11: replace and clear while linked
        set_force(1'b0);
        ch_level_i = 4'hF; idle(3);
        command(4'b0011); check_link("R11 first", 4'b0011);
        command(4'b0100); check_link("R11 replace", 4'b0100);
        command(4'b0000); check_link("R11 clear", 4'b0000);

        // R6: stuck-low while linked, with a command in the same cycle
        command(4'b1001); check_link("R6 pre", 4'b1001);
        @(negedge clk); stuck_low_i = 1'b1; cmd_valid_i = 1'b1; cmd_mask_i = 4'b0110;
        @(negedge clk); cmd_valid_i = 1'b0;
        check_link("R6 drop", 4'b0000);
        stuck_low_i = 1'b0;

        // R10: level rising one cycle before the command edge
        ch_level_i = 4'h0; idle(3);
        @(negedge clk); ch_level_i = 4'b0001;
        command(4'b0001); check_link("R10 early", 4'b0000);
        idle(2);
        command(4'b0001); check_link("R10 settled", 4'b0001);

        // R7: enable low clears state and ignores commands / writes
        set_force(1'b1);
        @(negedge clk); en_i = 1'b0;
        idle(1); check_link("R7 opened", 4'h0);
        @(negedge clk); cfg_we_i = 1'b1; cfg_force_i = 1'b1; cmd_valid_i = 1'b1; cmd_mask_i = 4'hF;
        @(negedge clk); cfg_we_i = 1'b0; cmd_valid_i = 1'b0;
        check_link("R7 cmd ignored", 4'h0);
        // R8: alert merge with enable low
        alert_n_i = 4'b1011; #1;
        chk("R8 any low", {7'h0, alert_n_o}, 8'h0);
        alert_n_i = 4'hF; #1;
        chk("R8 all high", {7'h0, alert_n_o}, 8'h1);
        @(negedge clk); en_i = 1'b1;
        ch_level_i = 4'h0; idle(3);
        command(4'b1000); check_link("R7 override cleared", 4'h0);

        // R9: lockout
        set_force(1'b1);
        command(4'b0010); check_link("R9 pre", 4'b0010);
        @(negedge clk); uvlo_i = 1'b1; alert_n_i = 4'h0;
        #1; chk("R9 alert released", {7'h0, alert_n_o}, 8'h1);
        idle(1); check_link("R9 opened", 4'h0);
        command(4'b0100); check_link("R9 cmd ignored", 4'h0);
        @(negedge clk); uvlo_i = 1'b0;
        #1; chk("R8 after lockout", {7'h0, alert_n_o}, 8'h0);
        alert_n_i = 4'hF;
        idle(2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule